// File: doc/BRIEF.md
# Flash access protection controller

This block keeps the protection bits of an on-chip flash and decides, in every cycle, whether a data access that falls into the flash address range may proceed. All bits follow the one-way rule of non-volatile cells. An erased bit is 1 and a programmed bit is 0. A bit can only ever move from 1 to 0. Reset brings the block to the state of a fresh part, with every bit erased.

There are three 16-bit registers:

- The guard register holds two live bits: bit 0 is the access lock and bit 1 is the debug lock. Its upper bits are reserved.
- The release register holds sixteen release bits.
- The confirm register holds sixteen confirm bits, one paired with each release bit.

A programming request names one register and carries a 16-bit mask of the bits to clear. The block applies a fixed ordering to the release and confirm bits. A request that breaks the ordering is refused as a whole, and the error output pulses.

The access decision is:

- With the access lock programmed, data accesses are refused, unless the instruction doing them was fetched from the flash.
- Any release bit that is programmed while its paired confirm bit is still erased cancels the access lock.
- The debug-enable output stays high for as long as the debug lock is erased.

A read port returns any register, so software and test can see the stored state.

Top module: `fap_ctrl`

## Requirements
- R1: After reset all three registers read 0xFFFF, `prog_err` is 0, `dbg_enable` is 1 and a data access with `acc_req`=1 is allowed. Select codes are 0 for the guard register, 1 for release, 2 for confirm and 3 unused. `rd_data` for select 3 is 0xFFFF.
- R2: An accepted request clears exactly the masked bits of the selected register that are still 1, and the new value is visible from the clock edge that samples the request. Guard register bits 15:2 are reserved: they always read 1, ignore the mask and never cause an error.
- R3: No bit ever returns from 0 to 1. A mask bit aimed at a bit that is already 0 changes nothing and is not checked against any ordering rule.
- R4: Release bit 0 may be cleared only when both guard bit 0 (access lock) and guard bit 1 (debug lock) are already 0.
- R5: Release bit x, for x of 1 or more, may be cleared only when confirm bit x-1 is already 0.
- R6: Confirm bit x may be cleared only when release bit x is already 0.
- R7: If any bit that a request would clear breaks R4, R5 or R6, no bit of any register changes. `prog_err` is then 1 for exactly the cycle after the request. A cycle without a refused request leaves `prog_err` at 0.
- R8: `acc_allow` is 0 whenever `acc_req` is 0. With `acc_req`=1, the access is refused only when guard bit 0 is 0, `acc_from_flash` is 0 and no release/confirm pair cancels the lock. Otherwise it is allowed.
- R9: A pair x with release bit x at 0 and confirm bit x at 1 cancels the access lock. Clearing the confirm bit of that pair restores the lock.
- R10: `dbg_enable` equals guard bit 1 (the debug lock) at all times.
- R11: A request with select code 3 changes no register and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, restores the fresh-part state |
| prog_valid | input | 1 | Programming request present this cycle |
| prog_sel | input | 2 | Target register: 0 guard, 1 release, 2 confirm, 3 unused |
| prog_mask | input | 16 | Bits to clear in the target register |
| rd_sel | input | 2 | Register selected for readback, same codes |
| rd_data | output | 16 | Current value of the selected register |
| acc_req | input | 1 | Data access to the flash range this cycle |
| acc_from_flash | input | 1 | Current instruction was fetched from the flash |
| acc_allow | output | 1 | The data access may proceed |
| dbg_enable | output | 1 | Debug and test features are available |
| prog_err | output | 1 | Previous cycle's request was refused |

## Verification
The checker checks the following on every cycle:

- No stored bit rises after reset.
- Each cleared release or confirm bit had its ordering precondition met in the cycle before.
- An error pulse coincides with unchanged registers.
- The reserved guard bits stay at 1.
- `dbg_enable` follows the debug lock.
- A locked, non-flash, unreleased access is refused.

Only the bench's scenarios can show the following:

- A refused request discards its legal bits too.
- Masks on already-programmed bits pass silently.
- The unused select code is inert.
- A lock that was cancelled by a half-done pair comes back once the pair is finished.

// File: rtl/fap_pkg.sv
package fap_pkg;

    localparam int REG_W  = 16;
    localparam int SEL_W  = 2;
    localparam int AP_BIT = 0;
    localparam int DP_BIT = 1;

    localparam logic [REG_W-1:0] GUARD_LIVE =
        (REG_W'(1) << AP_BIT) | (REG_W'(1) << DP_BIT);
    localparam logic [REG_W-1:0] ERASED = '1;

    typedef enum logic [SEL_W-1:0] {
        SEL_GUARD   = 2'd0,
        SEL_RELEASE = 2'd1,
        SEL_CONFIRM = 2'd2,
        SEL_NONE    = 2'd3
    } sel_e;

    typedef struct packed {
        logic             valid;
        sel_e             sel;
        logic [REG_W-1:0] mask;
    } prog_req_t;

    typedef struct packed {
        logic [REG_W-1:0] guard;
        logic [REG_W-1:0] rel;
        logic [REG_W-1:0] cnf;
    } prot_state_t;

    function automatic logic [REG_W-1:0] read_mux(prot_state_t s, sel_e sel);
        logic [REG_W-1:0] v;
        case (sel)
            SEL_GUARD:   v = s.guard;
            SEL_RELEASE: v = s.rel;
            SEL_CONFIRM: v = s.cnf;
            default:     v = ERASED;
        endcase
        return v;
    endfunction

    function automatic logic lock_cancelled(logic [REG_W-1:0] rel,
                                            logic [REG_W-1:0] cnf);
        return |(~rel & cnf);
    endfunction

endpackage

// File: rtl/fap_rule_check.sv
module fap_rule_check
    import fap_pkg::*;
(
    input  prot_state_t cur,
    input  prog_req_t   req,
    output prot_state_t nxt,
    output logic        accept,
    output logic        reject
);

    logic [REG_W-1:0] rel_ok;
    logic [REG_W-1:0] cnf_ok;
    logic [REG_W-1:0] clr_guard;
    logic [REG_W-1:0] clr_rel;
    logic [REG_W-1:0] clr_cnf;
    logic [REG_W-1:0] bad;

    // Precondition of each bit, from the stored state only.
    for (genvar i = 0; i < REG_W; i++) begin : g_order
        if (i == 0) begin : g_first
            assign rel_ok[i] = ~cur.guard[AP_BIT] & ~cur.guard[DP_BIT];
        end else begin : g_chain
            assign rel_ok[i] = ~cur.cnf[i-1];
        end
        assign cnf_ok[i] = ~cur.rel[i];
    end

    always_comb begin
        clr_guard = '0;
        clr_rel   = '0;
        clr_cnf   = '0;
        if (req.valid) begin
            case (req.sel)
                SEL_GUARD:   clr_guard = req.mask & cur.guard & GUARD_LIVE;
                SEL_RELEASE: clr_rel   = req.mask & cur.rel;
                SEL_CONFIRM: clr_cnf   = req.mask & cur.cnf;
                default: ;
            endcase
        end
        bad    = (clr_rel & ~rel_ok) | (clr_cnf & ~cnf_ok);
        reject = req.valid & (|bad);
        accept = req.valid & ~(|bad);
        nxt    = cur;
        if (accept) begin
            nxt.guard = cur.guard & ~clr_guard;
            nxt.rel   = cur.rel & ~clr_rel;
            nxt.cnf   = cur.cnf & ~clr_cnf;
        end
    end

endmodule

// File: rtl/fap_bit_store.sv
module fap_bit_store
    import fap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic        reject,
    input  prot_state_t nxt,
    output prot_state_t st_q,
    output logic        err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{guard: ERASED, rel: ERASED, cnf: ERASED};
            err_q <= 1'b0;
        end else begin
            if (accept) begin
                st_q <= nxt;
            end
            err_q <= reject;
        end
    end

endmodule

// File: rtl/fap_access_decide.sv
module fap_access_decide
    import fap_pkg::*;
(
    input  logic             acc_req,
    input  logic             acc_from_flash,
    input  logic             lock_erased,
    input  logic             dbg_erased,
    input  logic [REG_W-1:0] rel,
    input  logic [REG_W-1:0] cnf,
    output logic             acc_allow,
    output logic             dbg_enable
);

    logic cancel;

    always_comb begin
        cancel     = lock_cancelled(rel, cnf);
        acc_allow  = acc_req & (lock_erased | acc_from_flash | cancel);
        dbg_enable = dbg_erased;
    end

endmodule

// File: rtl/fap_ctrl.sv
module fap_ctrl
    import fap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_valid,
    input  logic [SEL_W-1:0] prog_sel,
    input  logic [REG_W-1:0] prog_mask,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             acc_req,
    input  logic             acc_from_flash,
    output logic             acc_allow,
    output logic             dbg_enable,
    output logic             prog_err
);

    prog_req_t   req;
    prot_state_t st_q;
    prot_state_t nxt;
    logic        accept;
    logic        reject;

    assign req = '{valid: prog_valid, sel: sel_e'(prog_sel), mask: prog_mask};

    fap_rule_check u_rules (
        .cur    (st_q),
        .req    (req),
        .nxt    (nxt),
        .accept (accept),
        .reject (reject)
    );

    fap_bit_store u_store (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .reject (reject),
        .nxt    (nxt),
        .st_q   (st_q),
        .err_q  (prog_err)
    );

    fap_access_decide u_decide (
        .acc_req        (acc_req),
        .acc_from_flash (acc_from_flash),
        .lock_erased    (st_q.guard[AP_BIT]),
        .dbg_erased     (st_q.guard[DP_BIT]),
        .rel            (st_q.rel),
        .cnf            (st_q.cnf),
        .acc_allow      (acc_allow),
        .dbg_enable     (dbg_enable)
    );

    assign rd_data = read_mux(st_q, sel_e'(rd_sel));

endmodule

// File: rtl/fap_ctrl_chk.sv
module fap_ctrl_chk
    import fap_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             prog_valid,
    input logic             acc_req,
    input logic             acc_from_flash,
    input logic             acc_allow,
    input logic             dbg_enable,
    input logic             prog_err,
    input logic [REG_W-1:0] guard,
    input logic [REG_W-1:0] rel,
    input logic [REG_W-1:0] cnf
);

    // R3: stored bits never rise
    a_r3_no_rise: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((guard & ~$past(guard)) | (rel & ~$past(rel)) |
                   (cnf & ~$past(cnf))) == '0));

    // R2: reserved guard bits stay erased
    a_r2_reserved_erased: assert property (@(posedge clk) disable iff (rst)
        (guard | GUARD_LIVE) == ERASED);

    // R4: release bit 0 falls only after both guard locks were programmed
    a_r4_first_release: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(rel[0]) && !rel[0]) |->
                  (!$past(guard[AP_BIT]) && !$past(guard[DP_BIT]))));

    // R5: release bit x falls only after confirm bit x-1 was programmed
    a_r5_release_chain: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(rel) & ~rel) & {$past(cnf[REG_W-2:0]), 1'b0}) == '0));

    // R6: confirm bit x falls only after release bit x was programmed
    a_r6_confirm_order: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(cnf) & ~cnf) & $past(rel)) == '0));

    // R7: an error pulse means nothing changed, and needs a request
    a_r7_err_no_change: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> ($stable(guard) && $stable(rel) && $stable(cnf)));

    a_r7_err_needs_req: assert property (@(posedge clk) disable iff (rst)
        !prog_valid |=> !prog_err);

    // R8: no request, no grant; locked non-flash unreleased access refused
    a_r8_no_req_no_allow: assert property (@(posedge clk) disable iff (rst)
        !acc_req |-> !acc_allow);

    a_r8_locked_refused: assert property (@(posedge clk) disable iff (rst)
        (acc_req && !acc_from_flash && !guard[AP_BIT] && ((rel | ~cnf) == ERASED))
        |-> !acc_allow);

    // R10: debug enable follows the debug lock
    a_r10_debug_follow: assert property (@(posedge clk) disable iff (rst)
        dbg_enable == guard[DP_BIT]);

endmodule

bind fap_ctrl fap_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .prog_valid     (prog_valid),
    .acc_req        (acc_req),
    .acc_from_flash (acc_from_flash),
    .acc_allow      (acc_allow),
    .dbg_enable     (dbg_enable),
    .prog_err       (prog_err),
    .guard          (st_q.guard),
    .rel            (st_q.rel),
    .cnf            (st_q.cnf)
);

// File: tb/tb_fap_ctrl.sv
`timescale 1ns/1ps
module tb_fap_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_valid = 1'b0;
    logic [1:0]  prog_sel = 2'd0;
    logic [15:0] prog_mask = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        acc_req = 1'b0;
    logic        acc_from_flash = 1'b0;
    logic        acc_allow;
    logic        dbg_enable;
    logic        prog_err;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    fap_ctrl dut (
        .clk(clk), .rst(rst), .prog_valid(prog_valid), .prog_sel(prog_sel),
        .prog_mask(prog_mask), .rd_sel(rd_sel), .rd_data(rd_data),
        .acc_req(acc_req), .acc_from_flash(acc_from_flash),
        .acc_allow(acc_allow), .dbg_enable(dbg_enable), .prog_err(prog_err)
    );

    // {sel, mask, expected error, expected readback of sel}
    localparam logic [34:0] VEC [0:10] = '{
        {2'd1, 16'h0001, 1'b1, 16'hFFFF},  // R4 locks still erased
        {2'd2, 16'h0001, 1'b1, 16'hFFFF},  // R6 release 0 still erased
        {2'd0, 16'hFFFF, 1'b0, 16'hFFFC},  // R2 reserved bits ignored
        {2'd1, 16'h0003, 1'b1, 16'hFFFF},  // R7 bit1 bad, bit0 also dropped
        {2'd1, 16'h0001, 1'b0, 16'hFFFE},  // R4 now legal
        {2'd2, 16'h0001, 1'b0, 16'hFFFE},  // R6 now legal
        {2'd1, 16'h0002, 1'b0, 16'hFFFC},  // R5 legal
        {2'd1, 16'h0004, 1'b1, 16'hFFFC},  // R5 confirm 1 erased
        {2'd3, 16'hFFFF, 1'b0, 16'hFFFF},  // R11 unused select
        {2'd1, 16'h0003, 1'b0, 16'hFFFC},  // R3 already-zero bits
        {2'd2, 16'h0002, 1'b0, 16'hFFFC}   // R6 legal
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prog(input logic [1:0] sel, input logic [15:0] mask);
        @(negedge clk);
        prog_valid = 1'b1;
        prog_sel   = sel;
        prog_mask  = mask;
        rd_sel     = sel;
        @(negedge clk);
        prog_valid = 1'b0;
        prog_mask  = '0;
        #1;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string req);
        rd_sel = sel;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic access(input logic req_i, input logic fl, input logic exp, input string req);
        acc_req = req_i;
        acc_from_flash = fl;
        #1;
        chk(req, acc_allow, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd(2'd0, 16'hFFFF, "R1 guard");
        rd(2'd1, 16'hFFFF, "R1 release");
        rd(2'd2, 16'hFFFF, "R1 confirm");
        rd(2'd3, 16'hFFFF, "R1 unused select");
        chk("R1 err", prog_err, 1'b0);
        chk("R1 dbg", dbg_enable, 1'b1);
        access(1'b1, 1'b0, 1'b1, "R1 allow");
        access(1'b0, 1'b0, 1'b0, "R8 idle");

        foreach (VEC[i]) begin
            prog(VEC[i][34:33], VEC[i][32:17]);
            chk($sformatf("R7 vec%0d err", i), prog_err, VEC[i][16]);
            chk($sformatf("R2 vec%0d rd", i), rd_data, VEC[i][15:0]);
        end

        // State now: guard FFFC, release FFFC, confirm FFFC
        chk("R10 dbg off", dbg_enable, 1'b0);
        access(1'b1, 1'b0, 1'b0, "R8 locked");
        access(1'b1, 1'b1, 1'b1, "R8 flash fetch");
        access(1'b0, 1'b1, 1'b0, "R8 no req");

        // R7 pulse lasts one cycle and leaves everything intact
        prog(2'd1, 16'h0008);
        chk("R7 refused", prog_err, 1'b1);
        @(negedge clk); #1;
        chk("R7 one cycle", prog_err, 1'b0);
        rd(2'd1, 16'hFFFC, "R7 release kept");

        // R11 unused select touches nothing
        prog(2'd3, 16'hFFFF);
        chk("R11 err", prog_err, 1'b0);
        rd(2'd0, 16'hFFFC, "R11 guard");
        rd(2'd1, 16'hFFFC, "R11 release");
        rd(2'd2, 16'hFFFC, "R11 confirm");

        // R9 a half-done pair cancels the lock, finishing it restores
        prog(2'd1, 16'h0004);
        chk("R5 release2 err", prog_err, 1'b0);
        rd(2'd1, 16'hFFF8, "R5 release2");
        access(1'b1, 1'b0, 1'b1, "R9 cancelled");
        prog(2'd2, 16'h0004);
        rd(2'd2, 16'hFFF8, "R6 confirm2");
        access(1'b1, 1'b0, 1'b0, "R9 restored");

        // R3 cannot reopen a bit
        prog(2'd2, 16'h0000);
        rd(2'd2, 16'hFFF8, "R3 confirm kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule